// File: doc/BRIEF.md
# EDID Block Read Sequencer

This block fetches one 128-byte EDID block from an attached display over the display data channel. It is given a block number and a start pulse. It then walks a byte-level I2C command engine through the enhanced addressing scheme. The block number is split into a segment value, which goes to the segment device, and a word offset of 0 or 128, which goes to the EDID device. The 128 bytes are collected as eight separate 16-byte transactions. Bit timing on SCL and SDA belongs to the command engine and is not handled here.

Each command goes out on `cmd_valid` together with an opcode, a write byte and a flag that says whether to NACK the read. It stays presented until the engine pulses `cmd_done`, which returns the target's acknowledge and any received byte. Every received byte leaves the block with a strobe and its position in the block. A one-cycle `done` pulse ends the operation and carries a status code. The hot-plug-detect input is checked before any bus traffic. A failed read of block 0 is attempted again a limited number of times.

Top module: `edid_block_reader`

## Requirements
- R1: If `hpd` is low when `start` is accepted, `done` pulses on the next cycle with status 1 (no device). No command is issued.
- R2: In every transaction the first write after the opening START carries 0x60. The write after it carries the segment value, which is `block_num` shifted right by one.
- R3: The word offset written to the EDID device is 128 for an odd block number and 0 for an even one. It increases by 16 for each later transaction of the same read.
- R4: Each transaction issues exactly this sequence, with opcodes START=0, WRITE=1, READ=2, STOP=3: START, WRITE 0x60, WRITE segment, START, WRITE 0xA0, WRITE offset, START, WRITE 0xA1, sixteen READs, STOP. Eight transactions make one read.
- R5: `cmd_rd_nack` is 0 on the first fifteen READs of a transaction and 1 on the sixteenth.
- R6: On the cycle after each READ completes, `byte_valid` pulses. `byte_data` holds the received byte and `byte_idx` holds its position 0 to 127 in the block. Within one attempt the positions count up in order.
- R7: If a command stays presented for POLL_LIMIT cycles without `cmd_done`, the attempt ends with status 3 (timeout) and no STOP is issued.
- R8: A read of block 0 that fails with a NACK or a timeout is run again from its first transaction, up to three attempts in total. Any other block gets a single attempt.
- R9: After the STOP of the eighth transaction completes, `done` pulses for exactly one cycle with status 0, and `busy` is low in that cycle.
- R10: If a WRITE completes with `cmd_ack` low, the next command presented is STOP. The attempt then fails with status 2 (NACK).
- R11: A `start` that arrives while `busy` is high is ignored. The read that is running continues with its own block number.
- R12: While `cmd_valid` is high and `cmd_done` has not arrived, the opcode, the write byte and the NACK flag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin reading the block named by `block_num` |
| block_num | input | 8 | EDID block number to read |
| hpd | input | 1 | Hot-plug detect, high when a display is attached |
| cmd_valid | output | 1 | A command is presented to the engine |
| cmd_op | output | 2 | Command opcode: 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_wdata | output | 8 | Byte sent by a WRITE |
| cmd_rd_nack | output | 1 | The READ answers its byte with NACK instead of ACK |
| cmd_done | input | 1 | The engine has finished the presented command |
| cmd_ack | input | 1 | The target acknowledged the completed WRITE |
| cmd_rdata | input | 8 | Byte received by the completed READ |
| byte_valid | output | 1 | A received EDID byte is on `byte_data` |
| byte_idx | output | 7 | Position of that byte within the block |
| byte_data | output | 8 | Received EDID byte |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle end-of-operation strobe |
| status | output | 2 | Result: 0 ok, 1 no device, 2 NACK, 3 timeout |

## Verification
Clean reads run on even and odd blocks that map to segments 0, 1 and 3, with different engine latencies. This separates the segment arithmetic from the choice of 0 or 128 for the offset base. NACKs are injected on the segment-device address, the segment byte, the EDID address and the offset byte, both on block 0 and on other blocks. This separates STOP-after-NACK and retry-from-the-beginning from single-attempt failure. A silent engine is tried on a write step and on a read step, which confirms the exact poll window and that block 0 recovers on a later attempt. A read with hot-plug low and a second start pulse during a busy read cover the gating and the ignore rule.

// File: rtl/edid_rd_pkg.sv
// Package: shared opcodes, status codes and fixed addresses for the EDID
// block reader. Assumes a byte-level command engine sits below the block.
package edid_rd_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } ddc_op_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_NODEV   = 2'd1,
        ST_NACK    = 2'd2,
        ST_TIMEOUT = 2'd3
    } rd_status_e;

    // 8-bit bus addresses (write forms, plus the read form of the EDID device)
    localparam logic [7:0] SEG_DEV_WR  = 8'h60;
    localparam logic [7:0] EDID_DEV_WR = 8'hA0;
    localparam logic [7:0] EDID_DEV_RD = 8'hA1;

    // Commands that come before the first READ of every transaction
    localparam int HDR_STEPS   = 8;
    localparam int BLOCK_BYTES = 128;

endpackage

// File: rtl/edid_step_decode.sv
// Step decoder: turns the position inside one transaction into the command
// presented to the engine. Assumes steps 0..7 are the addressing header,
// then CHUNK_BYTES reads, then a stop. Abort overrides everything with STOP.
module edid_step_decode
    import edid_rd_pkg::*;
#(
    parameter int CHUNK_BYTES = 16,
    parameter int STEP_W      = $clog2(HDR_STEPS + CHUNK_BYTES + 1)
) (
    input  logic [STEP_W-1:0] step,
    input  logic [7:0]        seg,
    input  logic [7:0]        offs,
    input  logic              abort,
    output logic [1:0]        op,
    output logic [7:0]        wdata,
    output logic              rd_nack,
    output logic              is_write,
    output logic              is_read,
    output logic              last_step
);
    localparam logic [STEP_W-1:0] RD_FIRST  = STEP_W'(HDR_STEPS);
    localparam logic [STEP_W-1:0] RD_LAST   = STEP_W'(HDR_STEPS + CHUNK_BYTES - 1);
    localparam logic [STEP_W-1:0] STOP_STEP = STEP_W'(HDR_STEPS + CHUNK_BYTES);

    ddc_op_e op_e;

    // Select the opcode and data byte for the current step
    always_comb begin
        op_e    = OP_START;
        wdata   = 8'h00;
        rd_nack = 1'b0;
        if (abort) begin
            op_e = OP_STOP;
        end else if (step >= RD_FIRST && step <= RD_LAST) begin
            op_e    = OP_READ;
            rd_nack = (step == RD_LAST);
        end else if (step == STOP_STEP) begin
            op_e = OP_STOP;
        end else begin
            case (step[2:0])
                3'd1: begin op_e = OP_WRITE; wdata = SEG_DEV_WR;  end
                3'd2: begin op_e = OP_WRITE; wdata = seg;         end
                3'd4: begin op_e = OP_WRITE; wdata = EDID_DEV_WR; end
                3'd5: begin op_e = OP_WRITE; wdata = offs;        end
                3'd7: begin op_e = OP_WRITE; wdata = EDID_DEV_RD; end
                default: op_e = OP_START;
            endcase
        end
    end

    // Classification flags used by the controller
    always_comb begin
        op        = op_e;
        is_write  = (op_e == OP_WRITE);
        is_read   = (op_e == OP_READ);
        last_step = !abort && (step == STOP_STEP);
    end

endmodule

// File: rtl/edid_poll_timer.sv
// Poll timer: counts the cycles a command has stayed presented without
// completion and flags expiry on the POLL_LIMIT-th such cycle. Assumes
// run drops for at least one cycle, or hit pulses, between commands.
module edid_poll_timer #(
    parameter int POLL_LIMIT = 4096,
    parameter int CNT_W      = $clog2(POLL_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hit,
    output logic expired
);
    logic [CNT_W-1:0] cnt_q;

    // Count cycles waited; restart on completion or when nothing is presented
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || hit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry: the current cycle is the last one allowed and it brought no completion
    always_comb begin
        expired = run && !hit && (cnt_q == CNT_W'(POLL_LIMIT - 1));
    end

endmodule

// File: rtl/edid_seq_ctrl.sv
// Sequence controller: holds the block number, transaction index, step and
// attempt count. Advances on engine completion and handles NACK, timeout and
// retry. Assumes CHUNK_BYTES is a power of two that divides 128.
module edid_seq_ctrl
    import edid_rd_pkg::*;
#(
    parameter int CHUNK_BYTES = 16,
    parameter int MAX_TRIES   = 3,
    parameter int STEP_W      = $clog2(HDR_STEPS + CHUNK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        block_num,
    input  logic              hpd,
    input  logic              cmd_done,
    input  logic              cmd_ack,
    input  logic [7:0]        cmd_rdata,
    input  logic              expired,
    input  logic              dec_is_write,
    input  logic              dec_is_read,
    input  logic              dec_last_step,
    output logic [STEP_W-1:0] step,
    output logic [7:0]        seg,
    output logic [7:0]        offs,
    output logic              abort,
    output logic              present,
    output logic              byte_valid,
    output logic [6:0]        byte_idx,
    output logic [7:0]        byte_data,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status
);
    localparam int NUM_CHUNKS = BLOCK_BYTES / CHUNK_BYTES;
    localparam int CHUNK_W    = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;
    localparam int CHUNK_SH   = $clog2(CHUNK_BYTES);
    localparam int TRY_W      = $clog2(MAX_TRIES + 1);

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_ABORT, S_GAP} seq_state_e;

    seq_state_e         state_q;
    logic [7:0]         blk_q;
    logic [CHUNK_W-1:0] chunk_q;
    logic [STEP_W-1:0]  step_q;
    logic [TRY_W-1:0]   tries_q;
    logic               done_q;
    logic [1:0]         status_q;
    logic               bv_q;
    logic [6:0]         bi_q;
    logic [7:0]         bd_q;

    logic [7:0]         chunk_base;
    logic [6:0]         rd_pos;
    logic               can_retry;
    logic               fail;
    rd_status_e         fail_code;

    // Address arithmetic: segment, word offset and position of the next read byte
    always_comb begin
        chunk_base = 8'(chunk_q) << CHUNK_SH;
        seg        = blk_q >> 1;
        offs       = {blk_q[0], 7'd0} + chunk_base;
        rd_pos     = 7'(step_q - STEP_W'(HDR_STEPS));
        can_retry  = (blk_q == 8'd0) && (tries_q < TRY_W'(MAX_TRIES - 1));
    end

    // Failure detection: timeout in any bus state, or completion of the abort stop
    always_comb begin
        fail      = 1'b0;
        fail_code = ST_OK;
        if (state_q == S_RUN || state_q == S_ABORT) begin
            if (expired) begin
                fail      = 1'b1;
                fail_code = ST_TIMEOUT;
            end else if (state_q == S_ABORT && cmd_done) begin
                fail      = 1'b1;
                fail_code = ST_NACK;
            end
        end
    end

    // Main sequencing register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            blk_q    <= 8'd0;
            chunk_q  <= '0;
            step_q   <= '0;
            tries_q  <= '0;
            done_q   <= 1'b0;
            status_q <= ST_OK;
            bv_q     <= 1'b0;
            bi_q     <= 7'd0;
            bd_q     <= 8'd0;
        end else begin
            done_q <= 1'b0;
            bv_q   <= 1'b0;
            if (fail) begin
                chunk_q <= '0;
                step_q  <= '0;
                if (can_retry) begin
                    tries_q <= tries_q + 1'b1;
                    state_q <= S_GAP;
                end else begin
                    state_q  <= S_IDLE;
                    done_q   <= 1'b1;
                    status_q <= fail_code;
                end
            end else begin
                case (state_q)
                    S_IDLE: begin
                        if (start) begin
                            blk_q   <= block_num;
                            chunk_q <= '0;
                            step_q  <= '0;
                            tries_q <= '0;
                            if (!hpd) begin
                                done_q   <= 1'b1;
                                status_q <= ST_NODEV;
                            end else begin
                                state_q <= S_RUN;
                            end
                        end
                    end
                    S_RUN: begin
                        if (cmd_done) begin
                            if (dec_is_write && !cmd_ack) begin
                                state_q <= S_ABORT;
                            end else begin
                                if (dec_is_read) begin
                                    bv_q <= 1'b1;
                                    bd_q <= cmd_rdata;
                                    bi_q <= chunk_base[6:0] + rd_pos;
                                end
                                if (dec_last_step) begin
                                    step_q <= '0;
                                    if (chunk_q == CHUNK_W'(NUM_CHUNKS - 1)) begin
                                        state_q  <= S_IDLE;
                                        done_q   <= 1'b1;
                                        status_q <= ST_OK;
                                    end else begin
                                        chunk_q <= chunk_q + 1'b1;
                                    end
                                end else begin
                                    step_q <= step_q + 1'b1;
                                end
                            end
                        end
                    end
                    S_GAP:   state_q <= S_RUN;
                    default: state_q <= state_q;
                endcase
            end
        end
    end

    // Output drive from registered state
    always_comb begin
        step       = step_q;
        abort      = (state_q == S_ABORT);
        present    = (state_q == S_RUN) || (state_q == S_ABORT);
        busy       = (state_q != S_IDLE);
        done       = done_q;
        status     = status_q;
        byte_valid = bv_q;
        byte_idx   = bi_q;
        byte_data  = bd_q;
    end

endmodule

// File: rtl/edid_block_reader.sv
// Top: EDID block reader. Connects the sequence controller, the step decoder
// and the poll timer. Assumes the command engine holds cmd_done high for one
// cycle per finished command and samples commands only while cmd_valid is high.
module edid_block_reader
    import edid_rd_pkg::*;
#(
    parameter int CHUNK_BYTES = 16,
    parameter int POLL_LIMIT  = 4096,
    parameter int MAX_TRIES   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] block_num,
    input  logic       hpd,
    output logic       cmd_valid,
    output logic [1:0] cmd_op,
    output logic [7:0] cmd_wdata,
    output logic       cmd_rd_nack,
    input  logic       cmd_done,
    input  logic       cmd_ack,
    input  logic [7:0] cmd_rdata,
    output logic       byte_valid,
    output logic [6:0] byte_idx,
    output logic [7:0] byte_data,
    output logic       busy,
    output logic       done,
    output logic [1:0] status
);
    localparam int STEP_W = $clog2(HDR_STEPS + CHUNK_BYTES + 1);

    logic [STEP_W-1:0] step;
    logic [7:0]        seg;
    logic [7:0]        offs;
    logic              abort;
    logic              present;
    logic              expired;
    logic              dec_is_write;
    logic              dec_is_read;
    logic              dec_last_step;

    edid_seq_ctrl #(
        .CHUNK_BYTES (CHUNK_BYTES),
        .MAX_TRIES   (MAX_TRIES),
        .STEP_W      (STEP_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .block_num     (block_num),
        .hpd           (hpd),
        .cmd_done      (cmd_done),
        .cmd_ack       (cmd_ack),
        .cmd_rdata     (cmd_rdata),
        .expired       (expired),
        .dec_is_write  (dec_is_write),
        .dec_is_read   (dec_is_read),
        .dec_last_step (dec_last_step),
        .step          (step),
        .seg           (seg),
        .offs          (offs),
        .abort         (abort),
        .present       (present),
        .byte_valid    (byte_valid),
        .byte_idx      (byte_idx),
        .byte_data     (byte_data),
        .busy          (busy),
        .done          (done),
        .status        (status)
    );

    edid_step_decode #(
        .CHUNK_BYTES (CHUNK_BYTES),
        .STEP_W      (STEP_W)
    ) u_dec (
        .step      (step),
        .seg       (seg),
        .offs      (offs),
        .abort     (abort),
        .op        (cmd_op),
        .wdata     (cmd_wdata),
        .rd_nack   (cmd_rd_nack),
        .is_write  (dec_is_write),
        .is_read   (dec_is_read),
        .last_step (dec_last_step)
    );

    edid_poll_timer #(
        .POLL_LIMIT (POLL_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (present),
        .hit     (cmd_done),
        .expired (expired)
    );

    // Present a command exactly while the controller is in a bus state
    always_comb begin
        cmd_valid = present;
    end

endmodule

// File: rtl/edid_block_reader_chk.sv
// Checker: protocol and sequencing properties of the EDID block reader,
// observed at its ports. Keeps its own wait counter for the poll window.
module edid_block_reader_chk #(
    parameter int CHUNK_BYTES = 16,
    parameter int POLL_LIMIT  = 4096
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       hpd,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic [7:0] cmd_wdata,
    input logic       cmd_rd_nack,
    input logic       cmd_done,
    input logic       cmd_ack,
    input logic       byte_valid,
    input logic [6:0] byte_idx,
    input logic       busy,
    input logic       done,
    input logic [1:0] status
);
    logic [31:0] wait_cnt;

    // Consecutive cycles a command has been presented without completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= 32'd0;
        end else if (!cmd_valid || cmd_done) begin
            wait_cnt <= 32'd0;
        end else begin
            wait_cnt <= wait_cnt + 32'd1;
        end
    end

    p_nodev_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !hpd) |=> (done && status == 2'd1 && !cmd_valid));

    p_read_nack_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> ($past(cmd_rd_nack) == (((32'(byte_idx) + 1) % CHUNK_BYTES) == 0)));

    p_byte_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> ($past(cmd_valid && cmd_done && cmd_op == 2'd2) && busy));

    p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (wait_cnt < POLL_LIMIT));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !cmd_valid));

    p_stop_after_nack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_done && cmd_op == 2'd1 && !cmd_ack) |=> (cmd_valid && cmd_op == 2'd3));

    p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done && wait_cnt < POLL_LIMIT - 1)
        |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_wdata) && $stable(cmd_rd_nack)));

endmodule

bind edid_block_reader edid_block_reader_chk #(
    .CHUNK_BYTES (CHUNK_BYTES),
    .POLL_LIMIT  (POLL_LIMIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .hpd         (hpd),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_wdata   (cmd_wdata),
    .cmd_rd_nack (cmd_rd_nack),
    .cmd_done    (cmd_done),
    .cmd_ack     (cmd_ack),
    .byte_valid  (byte_valid),
    .byte_idx    (byte_idx),
    .busy        (busy),
    .done        (done),
    .status      (status)
);

// File: tb/tb_edid_block_reader.sv
// Bench: behavioural engine-plus-display model. It predicts every command,
// returns bytes from a computed EDID image and checks every byte strobe.
module tb_edid_block_reader;
    localparam int CLK_PERIOD = 10;
    localparam int POLL       = 12;
    localparam int PER_CHUNK  = 25;
    localparam int PER_READ   = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] block_num = 8'd0;
    logic       hpd = 1'b1;
    logic       cmd_valid;
    logic [1:0] cmd_op;
    logic [7:0] cmd_wdata;
    logic       cmd_rd_nack;
    logic       cmd_done = 1'b0;
    logic       cmd_ack = 1'b0;
    logic [7:0] cmd_rdata = 8'd0;
    logic       byte_valid;
    logic [6:0] byte_idx;
    logic [7:0] byte_data;
    logic       busy;
    logic       done;
    logic [1:0] status;

    int n_checks = 0;
    int n_fail   = 0;

    // engine model state
    int lat = 1;
    int fault_kind = 0;       // 0 none, 1 nack, 2 hang
    int fault_k = 0;
    int fault_attempts = 0;
    int eng_k = 0;
    int eng_attempt = 0;
    int eng_cmds = 0;
    bit aborting = 0;
    int slv_seg = 0;
    int slv_ptr = 0;
    int cur_block = 0;
    int bytes_seen = 0;
    int prev_idx = -1;

    edid_block_reader #(.CHUNK_BYTES(16), .POLL_LIMIT(POLL), .MAX_TRIES(3)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .block_num(block_num), .hpd(hpd),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
        .cmd_rd_nack(cmd_rd_nack), .cmd_done(cmd_done), .cmd_ack(cmd_ack),
        .cmd_rdata(cmd_rdata), .byte_valid(byte_valid), .byte_idx(byte_idx),
        .byte_data(byte_data), .busy(busy), .done(done), .status(status)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int edid_byte(input int sg, input int addr);
        return (sg * 29 + addr * 7 + 3) & 255;
    endfunction

    // expected command k of one attempt, packed as op*512 + data*2 + nack
    function automatic int exp_cmd(input int k, input int blk);
        int s = k % PER_CHUNK;
        int c = k / PER_CHUNK;
        if (s >= 8 && s <= 23) return 2 * 512 + ((s == 23) ? 1 : 0);
        if (s == 24) return 3 * 512;
        case (s)
            1: return 512 + 2 * 8'h60;
            2: return 512 + 2 * (blk >> 1);
            4: return 512 + 2 * 8'hA0;
            5: return 512 + 2 * ((blk & 1) * 128 + c * 16);
            7: return 512 + 2 * 8'hA1;
            default: return 0;
        endcase
    endfunction

    task automatic serve_one();
        int act, expv, s, hang;
        bit faulty;
        string req;
        s   = eng_k % PER_CHUNK;
        act = int'(cmd_op) * 512 + ((cmd_op == 2'd1) ? int'(cmd_wdata) : 0) * 2 + int'(cmd_rd_nack);
        expv = aborting ? 3 * 512 : exp_cmd(eng_k, cur_block);
        if (aborting) req = "R10";
        else if (s == 2) req = "R2";
        else if (s == 5) req = "R3";
        else if (s >= 8 && s <= 23) req = "R5";
        else req = "R4";
        chk(act == expv, req, "command", act, expv);
        eng_cmds++;
        faulty = (fault_kind != 0) && (eng_attempt < fault_attempts) && (eng_k == fault_k) && !aborting;
        if (faulty && fault_kind == 2) begin
            hang = 0;
            while (cmd_valid === 1'b1 && hang < 1000) begin
                @(negedge clk);
                hang++;
            end
            chk(hang == POLL, "R7", "poll window cycles", hang, POLL);
            eng_attempt++;
            eng_k = 0;
            return;
        end
        repeat (lat) @(negedge clk);
        cmd_done = 1'b1;
        cmd_ack  = !(faulty && fault_kind == 1);
        if (cmd_op == 2'd2) begin
            cmd_rdata = 8'(edid_byte(slv_seg, slv_ptr));
            slv_ptr   = (slv_ptr + 1) & 255;
        end else if (cmd_op == 2'd1 && !aborting) begin
            if (s == 2) slv_seg = int'(cmd_wdata);
            if (s == 5) slv_ptr = int'(cmd_wdata);
        end
        @(negedge clk);
        cmd_done = 1'b0;
        if (aborting) begin
            aborting = 0;
            eng_attempt++;
            eng_k = 0;
        end else if (faulty && fault_kind == 1) begin
            aborting = 1;
        end else begin
            eng_k++;
            if (eng_k == PER_READ) eng_k = 0;
        end
    endtask

    // engine: serve every presented command
    initial begin
        forever begin
            @(negedge clk);
            while (cmd_valid === 1'b1) serve_one();
        end
    end

    // byte monitor, every clock
    always @(negedge clk) begin
        if (rst_n && byte_valid === 1'b1) begin
            chk(int'(byte_idx) == prev_idx + 1 || byte_idx == 7'd0, "R6", "byte order",
                int'(byte_idx), prev_idx + 1);
            chk(int'(byte_data) == edid_byte(cur_block >> 1, (cur_block & 1) * 128 + int'(byte_idx)),
                "R6", "byte data", int'(byte_data),
                edid_byte(cur_block >> 1, (cur_block & 1) * 128 + int'(byte_idx)));
            prev_idx = int'(byte_idx);
            bytes_seen++;
        end
    end

    task automatic run_read(input int blk, input bit hpd_v, input int lat_v,
                            input int fk, input int fkk, input int fatt, input int poke_at,
                            input int exp_status, input int exp_bytes, input int exp_failed,
                            input string req);
        int cyc;
        lat = lat_v; fault_kind = fk; fault_k = fkk; fault_attempts = fatt;
        eng_k = 0; eng_attempt = 0; eng_cmds = 0; aborting = 0;
        bytes_seen = 0; prev_idx = -1; cur_block = blk;
        @(negedge clk);
        hpd = hpd_v; block_num = 8'(blk); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (done !== 1'b1 && cyc < 30000) begin
            if (cyc == poke_at) begin
                start = 1'b1;
                block_num = 8'd4;
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        chk(done === 1'b1, req, "done seen", int'(done), 1);
        chk(int'(status) == exp_status, req, "status", int'(status), exp_status);
        chk(busy === 1'b0, "R9", "busy at done", int'(busy), 0);
        chk(bytes_seen == exp_bytes, req, "bytes received", bytes_seen, exp_bytes);
        chk(eng_attempt == exp_failed, "R8", "failed attempts", eng_attempt, exp_failed);
        if (!hpd_v) chk(eng_cmds == 0, "R1", "commands issued", eng_cmds, 0);
        @(negedge clk);
        chk(done === 1'b0, "R9", "done width", int'(done), 0);
        hpd = 1'b1;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_valid === 1'b0 && busy === 1'b0 && done === 1'b0 && byte_valid === 1'b0,
            "R9", "reset state", int'({cmd_valid, busy, done, byte_valid}), 0);
        // R1 no device
        run_read(4, 1'b0, 1, 0, 0, 0, -1, 1, 0, 0, "R1");
        // R4 R9 clean reads on several segments and latencies
        run_read(0, 1'b1, 1, 0, 0, 0, -1, 0, 128, 0, "R9");
        run_read(3, 1'b1, 0, 0, 0, 0, -1, 0, 128, 0, "R3");
        run_read(6, 1'b1, 3, 0, 0, 0, -1, 0, 128, 0, "R2");
        // R10 NACK on EDID address, single attempt for non-zero block
        run_read(5, 1'b1, 1, 1, 4, 3, -1, 2, 0, 1, "R10");
        run_read(2, 1'b1, 2, 1, 30, 3, -1, 2, 16, 1, "R10");
        // R8 block 0 recovers after two NACKed attempts
        run_read(0, 1'b1, 1, 1, 1, 2, -1, 0, 128, 2, "R8");
        // R8 block 0 fails three times
        run_read(0, 1'b1, 1, 1, 52, 3, -1, 2, 96, 3, "R8");
        // R7 timeout on a write step of block 7
        run_read(7, 1'b1, 1, 2, 26, 3, -1, 3, 16, 1, "R7");
        // R7 R8 block 0 hang on a read step, then success
        run_read(0, 1'b1, 1, 2, 9, 1, -1, 0, 129, 1, "R7");
        // R7 R8 block 0 hang every attempt
        run_read(0, 1'b1, 1, 2, 0, 3, -1, 3, 0, 3, "R7");
        // R11 second start during a busy read is ignored
        run_read(1, 1'b1, 1, 0, 0, 0, 30, 0, 128, 0, "R11");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule